// File: doc/BRIEF.md
# Clock-Loss Power Mode Controller

This block runs from a free-running reference oscillator. It decides the operating mode of a converter's power domains. It has three inputs that set the mode: an external active-low power-down pin, a power-enable register bit and a reset-release register bit. It also watches the master audio clock for edges. The master clock is brought into the reference domain through a synchronizer, and any toggle of the synchronized value counts as an edge. If no edge arrives within a window of about one microsecond, the master clock is declared lost.

The mode is chosen by strict priority. The power-down pin comes first, then clock loss, then the power-enable bit, then the reset-release bit. The block drives these outputs:
- enables for the digital core, the analog core, the regulator and the register file;
- a two-bit analog output state;
- an enable for zero-data detection.

When the master clock comes back, the block returns to normal operation on its own if both register bits are 1. No new power-up sequence is needed. Several consecutive edges are required before the clock counts as present, so that a single glitch cannot wake the device.

Top module: `clk_loss_pwr_ctrl`

## Requirements
- R1: While `pdnPinN` is 0, every output is 0 at once, without waiting for a clock edge. This means all enables are off and `aoutState` is 2'b00 (high impedance). The clock watchdog is also cleared, so after the pin is released the block starts in the clock-stopped mode.
- R2: With the pin high and either the clock lost or `pwrEnBit` = 0, the outputs are: `digEn`=0, `anaEn`=0, `regulEn`=1, `regFileEn`=1, `aoutState`=2'b00.
- R3: Clock loss takes priority over the register bits. With the clock lost, the outputs are the R2 values for every setting of `pwrEnBit` and `rstRelBit`.
- R4: With the clock present, `pwrEnBit`=1 and `rstRelBit`=0, the outputs are: `digEn`=0, `anaEn`=1, `regulEn`=1, `regFileEn`=1, `aoutState`=2'b01 (common-mode hold).
- R5: With the clock present and both bits at 1, every enable is 1 and `aoutState` is 2'b10 (signal).
- R6: The clock is declared lost when TIMEOUT_CYC = ceil(REF_FREQ_KHZ/1000) reference cycles pass with no synchronized edge. The outputs change exactly TIMEOUT_CYC+4 reference edges after the last toggle of `mclkIn`. Up to and including edge TIMEOUT_CYC+3, they still show the previous mode.
- R7: `zeroDetEn` is 1 exactly when the pin is high and the clock is present. It is therefore 0 whenever the clock is lost.
- R8: After a loss, the clock becomes present again once RESUME_EDGES toggles arrive with no timeout between them. The outputs show the new mode 4 reference edges after the last of those toggles. This happens without any change of the pin or the register bits.
- R9: A lone toggle followed by a full timeout does not count towards resuming. After such a timeout, RESUME_EDGES new edges are again needed.
- R10: A change of `pwrEnBit` or `rstRelBit` reaches the outputs on the first reference edge after the change.
- R11: While toggles arrive closer together than the timeout, the mode stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| pdnPinN | input | 1 | Power-down pin, active low, asynchronous clear |
| pwrEnBit | input | 1 | Power-enable register bit |
| rstRelBit | input | 1 | Reset-release register bit (0 holds reset) |
| mclkIn | input | 1 | Master audio clock, asynchronous to refClk |
| digEn | output | 1 | Digital core enable |
| anaEn | output | 1 | Analog core enable |
| regulEn | output | 1 | Regulator enable |
| regFileEn | output | 1 | Register file retention enable |
| aoutState | output | 2 | Analog output: 00 high-Z, 01 common-mode, 10 signal |
| zeroDetEn | output | 1 | Zero-data detection enable |

## Verification
The assertions assume three things about the inputs:
- The register bits are quasi-static with respect to the reference clock, because they are used without a synchronizer.
- The power-down pin is the only asynchronous control.
- The master clock either toggles well inside the timeout window or stays silent for longer than it.

The bench keeps within these assumptions by driving every input at the falling edge of the reference clock. It runs the master clock with a toggle every two reference cycles, against a timeout of eight cycles in the bench configuration. It produces isolated toggles only where a timeout or a resume is the thing under test.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

  typedef enum logic [1:0] {
    AOUT_HIZ = 2'b00,
    AOUT_VCM = 2'b01,
    AOUT_SIG = 2'b10
  } aout_e;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_CLKSTOP,
    MODE_PWROFF,
    MODE_RESET,
    MODE_RUN
  } mode_e;

  // Strobes and status handed from the clock watchdog to the mode control
  typedef struct packed {
    logic edgeStb;
    logic lossStb;
    logic clkPresent;
  } watch_s;

endpackage

// File: rtl/mclk_watch.sv
module mclk_watch
  import pwrctl_pkg::*;
#(
  parameter int TIMEOUT_CYC  = 50,
  parameter int RESUME_EDGES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic   refClk,
  input  logic   rstN,
  input  logic   mclkIn,
  output watch_s stat
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int EW = $clog2(RESUME_EDGES + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LOSS_AT  = CW'(TIMEOUT_CYC - 1);
  localparam logic [EW-1:0] RES_AT   = EW'(RESUME_EDGES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CW-1:0]          idleCnt;
  logic [EW-1:0]          edgeCnt;
  logic                   presentQ;
  logic                   edgeStb;
  logic                   lossStb;
  logic                   resumeHit;

  // Synchronizer chain plus one delay stage for toggle detection
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], mclkIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign edgeStb   = syncQ[SYNC_STAGES-1] ^ prevQ;
  assign lossStb   = !edgeStb && (idleCnt == LOSS_AT);
  assign resumeHit = edgeStb && !presentQ && (edgeCnt == RES_AT);

  // Idle window: cycles since the last edge, saturating
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (edgeStb) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // Consecutive-edge qualifier and clock-present flag
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt  <= '0;
      presentQ <= 1'b0;
    end else if (lossStb) begin
      edgeCnt  <= '0;
      presentQ <= 1'b0;
    end else if (resumeHit) begin
      edgeCnt  <= '0;
      presentQ <= 1'b1;
    end else if (edgeStb && !presentQ) begin
      edgeCnt  <= edgeCnt + 1'b1;
    end
  end

  assign stat = '{edgeStb: edgeStb, lossStb: lossStb, clkPresent: presentQ};

  // R8: presence can only be regained on a detected edge
  a_r8_resume_on_edge: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(presentQ) |-> $past(edgeStb));

  // R6: presence is only dropped after a full idle window
  a_r6_loss_needs_idle: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(presentQ) |-> $past(idleCnt) == LOSS_AT);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwrctl_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       pwrEnBit,
  input  logic       rstRelBit,
  input  watch_s     stat,
  output logic       digEn,
  output logic       anaEn,
  output logic       regulEn,
  output logic       regFileEn,
  output logic [1:0] aoutState,
  output logic       zeroDetEn
);

  mode_e modeQ, modeNext;

  // Priority: pin (async reset) > clock loss > power enable > reset release
  always_comb begin
    if (!stat.clkPresent)  modeNext = MODE_CLKSTOP;
    else if (!pwrEnBit)    modeNext = MODE_PWROFF;
    else if (!rstRelBit)   modeNext = MODE_RESET;
    else                   modeNext = MODE_RUN;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_OFF;
    else       modeQ <= modeNext;
  end

  always_comb begin
    digEn     = 1'b0;
    anaEn     = 1'b0;
    regulEn   = 1'b1;
    regFileEn = 1'b1;
    aoutState = AOUT_HIZ;
    zeroDetEn = 1'b0;
    case (modeQ)
      MODE_OFF: begin
        regulEn   = 1'b0;
        regFileEn = 1'b0;
      end
      MODE_CLKSTOP: ;
      MODE_PWROFF: zeroDetEn = 1'b1;
      MODE_RESET: begin
        anaEn     = 1'b1;
        aoutState = AOUT_VCM;
        zeroDetEn = 1'b1;
      end
      MODE_RUN: begin
        digEn     = 1'b1;
        anaEn     = 1'b1;
        aoutState = AOUT_SIG;
        zeroDetEn = 1'b1;
      end
      default: begin
        regulEn   = 1'b0;
        regFileEn = 1'b0;
      end
    endcase
  end

  a_r2_stop_hiz: assert property (@(posedge refClk) disable iff (!rstN)
    !stat.clkPresent |=> (aoutState == AOUT_HIZ) && !digEn && !anaEn && regulEn && regFileEn);

  a_r3_loss_beats_bits: assert property (@(posedge refClk) disable iff (!rstN)
    (!stat.clkPresent && pwrEnBit && !rstRelBit) |=> (aoutState == AOUT_HIZ) && !anaEn);

  a_r4_reset_hold: assert property (@(posedge refClk) disable iff (!rstN)
    (stat.clkPresent && pwrEnBit && !rstRelBit) |=> anaEn && !digEn && (aoutState == AOUT_VCM));

  a_r5_run_all_on: assert property (@(posedge refClk) disable iff (!rstN)
    (stat.clkPresent && pwrEnBit && rstRelBit) |=> digEn && anaEn && (aoutState == AOUT_SIG));

  a_r7_zero_off: assert property (@(posedge refClk) disable iff (!rstN)
    !stat.clkPresent |=> !zeroDetEn);

  a_r6_loss_reaches_out: assert property (@(posedge refClk) disable iff (!rstN)
    stat.lossStb |=> ##1 !digEn && !zeroDetEn);

  a_r11_edge_keeps: assert property (@(posedge refClk) disable iff (!rstN)
    (stat.edgeStb && stat.clkPresent) |=> stat.clkPresent);

  a_r1_regul_on: assert property (@(posedge refClk) disable iff (!rstN)
    1'b1 |=> regulEn && regFileEn);

endmodule

// File: rtl/clk_loss_pwr_ctrl.sv
module clk_loss_pwr_ctrl
  import pwrctl_pkg::*;
#(
  parameter int REF_FREQ_KHZ = 50000,
  parameter int RESUME_EDGES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       refClk,
  input  logic       pdnPinN,
  input  logic       pwrEnBit,
  input  logic       rstRelBit,
  input  logic       mclkIn,
  output logic       digEn,
  output logic       anaEn,
  output logic       regulEn,
  output logic       regFileEn,
  output logic [1:0] aoutState,
  output logic       zeroDetEn
);

  // One microsecond of reference cycles, rounded up
  localparam int TIMEOUT_CYC = (REF_FREQ_KHZ + 999) / 1000;

  watch_s watchStat;

  mclk_watch #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .RESUME_EDGES(RESUME_EDGES),
    .SYNC_STAGES (SYNC_STAGES)
  ) uWatch (
    .refClk(refClk),
    .rstN  (pdnPinN),
    .mclkIn(mclkIn),
    .stat  (watchStat)
  );

  pwr_mode_ctrl uCtrl (
    .refClk   (refClk),
    .rstN     (pdnPinN),
    .pwrEnBit (pwrEnBit),
    .rstRelBit(rstRelBit),
    .stat     (watchStat),
    .digEn    (digEn),
    .anaEn    (anaEn),
    .regulEn  (regulEn),
    .regFileEn(regFileEn),
    .aoutState(aoutState),
    .zeroDetEn(zeroDetEn)
  );

endmodule

// File: tb/clk_loss_pwr_ctrl_test.sv
module clk_loss_pwr_ctrl_test;

  localparam int KHZ = 8000;
  localparam int TO  = (KHZ + 999) / 1000;

  logic       refClk = 1'b0;
  logic       pdnPinN, pwrEnBit, rstRelBit, mclkIn;
  logic       digEn, anaEn, regulEn, regFileEn, zeroDetEn;
  logic [1:0] aoutState;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  tgl = 1'b0;

  always #5 refClk = ~refClk;

  clk_loss_pwr_ctrl #(.REF_FREQ_KHZ(KHZ), .RESUME_EDGES(2), .SYNC_STAGES(2)) uut (
    .refClk(refClk), .pdnPinN(pdnPinN), .pwrEnBit(pwrEnBit), .rstRelBit(rstRelBit),
    .mclkIn(mclkIn), .digEn(digEn), .anaEn(anaEn), .regulEn(regulEn),
    .regFileEn(regFileEn), .aoutState(aoutState), .zeroDetEn(zeroDetEn)
  );

  // {dig, ana, regul, regfile, aout[1:0], zeroDet}
  function automatic logic [6:0] expOut(bit pin, bit pres, bit pw, bit rs);
    if (!pin)              return 7'b0000_00_0;
    else if (!pres || !pw) return {4'b0011, 2'b00, pres};
    else if (!rs)          return {4'b0111, 2'b01, 1'b1};
    else                   return {4'b1111, 2'b10, 1'b1};
  endfunction

  task automatic check(string req, logic [6:0] exp);
    logic [6:0] obs;
    obs = {digEn, anaEn, regulEn, regFileEn, aoutState, zeroDetEn};
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, obs, exp);
    end
  endtask

  task automatic cyc(bit run);
    @(negedge refClk);
    if (run) begin
      tgl = ~tgl;
      if (tgl) mclkIn = ~mclkIn;
    end
  endtask

  task automatic cycN(int n, bit run);
    for (int i = 0; i < n; i++) cyc(run);
  endtask

  task automatic toggleNow();
    @(negedge refClk);
    mclkIn = ~mclkIn;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pdnPinN = 1'b0; pwrEnBit = 1'b0; rstRelBit = 1'b0; mclkIn = 1'b0;
    cycN(4, 1);
    check("R1 pin low reset state", expOut(0, 0, 0, 0));

    // Release pin with the master clock silent
    pdnPinN = 1'b1;
    cycN(2, 0);
    check("R1 R2 R7 stopped after pin release", expOut(1, 0, 0, 0));
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 2; r++) begin
        pwrEnBit = p[0]; rstRelBit = r[0];
        cyc(0);
        check("R3 R7 clock loss overrides bits", expOut(1, 0, p[0], r[0]));
      end
    end

    // Clock starts: resume without any pin or bit sequence
    pwrEnBit = 1'b1; rstRelBit = 1'b1;
    cycN(12, 1);
    check("R8 R5 normal after clock start", expOut(1, 1, 1, 1));

    // Sweep bit combos with clock present
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 2; r++) begin
        pwrEnBit = p[0]; rstRelBit = r[0];
        cyc(1);
        check("R10 R2 R4 R5 mode one edge after bit change", expOut(1, 1, p[0], r[0]));
        cycN(20, 1);
        check("R11 mode steady with running clock", expOut(1, 1, p[0], r[0]));
      end
    end

    // Exact timeout position
    pwrEnBit = 1'b1; rstRelBit = 1'b1;
    cycN(4, 1);
    toggleNow();
    cycN(TO + 3, 0);
    check("R6 still normal before timeout", expOut(1, 1, 1, 1));
    cyc(0);
    check("R6 R7 stopped after timeout", expOut(1, 0, 1, 1));

    // Exact resume position
    cycN(5, 0);
    toggleNow();
    cyc(0);
    toggleNow();
    cycN(3, 0);
    check("R8 not yet resumed", expOut(1, 0, 1, 1));
    cyc(0);
    check("R8 resumed after second edge", expOut(1, 1, 1, 1));

    // Glitch rejection
    cycN(TO + 5, 0);
    check("R6 stopped again", expOut(1, 0, 1, 1));
    toggleNow();
    cycN(TO + 6, 0);
    check("R9 lone edge does not resume", expOut(1, 0, 1, 1));
    toggleNow();
    cycN(6, 0);
    check("R9 count restarted after timeout", expOut(1, 0, 1, 1));
    toggleNow();
    cycN(4, 0);
    check("R8 two edges in window resume", expOut(1, 1, 1, 1));

    // Asynchronous power-down mid-run
    cycN(6, 1);
    pdnPinN = 1'b0;
    #1;
    check("R1 async clear without clock edge", expOut(0, 0, 0, 0));
    cycN(3, 1);
    check("R1 held off while pin low", expOut(0, 0, 0, 0));
    pdnPinN = 1'b1;
    cyc(1);
    check("R1 watchdog cleared by pin", expOut(1, 0, 1, 1));
    cycN(10, 1);
    check("R8 normal again after pin cycle", expOut(1, 1, 1, 1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule